// File: doc/BRIEF.md
# I2C Single-Byte Register Target

This block is a target on a two-wire serial bus that answers at one 7-bit address, fixed by a parameter, and holds one 8-bit register. A bus controller writes the register by sending data bytes after the address, and it reads the register back as often as it likes. Local logic can also load the register with a one-cycle strobe, and the register is always visible on a parallel output.

The clock and data pins come in as separate input and output lines, as for open-drain pads: an output at 0 pulls the wire low, and an output at 1 releases it. Both inputs pass through a synchronizer and a counting glitch filter before any edge or bus condition is decoded. The target never holds the clock line low, so it cannot slow the controller down. It is built to follow a bus clock of roughly 30 system clocks per bit.

Top module: `i2c_byte_target`

## Requirements
- R1: After reset the register reads 0x00 and both pin outputs are released (1).
- R2: The first byte after a start condition is a 7-bit address, MSB first, followed by a direction bit (1 = read, 0 = write). When the address equals DEV_ADDR (default 0x70), the target pulls SDA low for the acknowledge bit that follows.
- R3: In a write, every data byte (MSB first) is acknowledged, and the register ends up holding the last complete byte. For example, 0x11 then 0xAA leaves 0xAA. This holds with an SCL period of 32 system clocks.
- R4: A write that carries an address but no data bytes leaves the register unchanged.
- R5: In a read of N bytes, every byte returns the register value MSB first. The target changes SDA only while the filtered SCL is low.
- R6: A one-cycle load_strobe copies load_data into the register, and the new value is on reg_value from the next clock.
- R7: A transaction to any other address is not acknowledged, never pulls SDA low and does not change the register.
- R8: If the controller does not acknowledge a read byte, the target releases SDA and ignores further clocks (they read back as 0xFF) until a stop or a repeated start. A repeated start to its own address is then served normally.
- R9: A level on either pin is accepted only after SYNC_STAGES synchronizer stages and FILTER_LEN consecutive identical samples. The target therefore acts on a pin change SYNC_STAGES+FILTER_LEN+1 clocks later (7 with defaults), and a pulse of FILTER_LEN-1 clocks on SCL or SDA has no effect.
- R10: A written byte takes effect in the clock where the filtered SCL falls after its eighth bit. If load_strobe falls in that same clock, the byte from the bus is kept. A strobe one clock later wins.
- R11: A stop or start condition in the middle of a data byte abandons the byte and leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| scl_i | input | 1 | Bus clock wire level |
| scl_o | output | 1 | Bus clock pull control (always released) |
| sda_i | input | 1 | Bus data wire level |
| sda_o | output | 1 | Bus data pull control, 0 pulls the wire low |
| load_data | input | 8 | Value for a local load |
| load_strobe | input | 1 | One-cycle local load request |
| reg_value | output | 8 | Current register contents |

## Verification
Two register updates can meet in the same clock: the local load strobe, and the completion of a bus-written byte at the falling SCL edge after its eighth bit. The bench counts the filter latency from the moment it drops SCL and places the strobe exactly on the commit clock, where the bus byte must survive. It then repeats the write with the strobe one clock later, where the strobe value must survive. Only a design whose commit clock and priority both match the requirement passes both checks.

// File: rtl/i2c_byte_target_pkg.sv
`timescale 1ns / 1ps
package i2c_byte_target_pkg;

  localparam int BYTE_W   = 8;
  localparam int BITCNT_W = 4;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_ADDR,
    TS_ADDR_ACK,
    TS_WR,
    TS_WR_ACK,
    TS_RD,
    TS_RD_ACK,
    TS_WAIT
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_filter.sv
`timescale 1ns / 1ps
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level
);

  localparam int CNT_W = $clog2(FILTER_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILTER_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_out;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   level_q, level_d;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_in;
      end
    end
  endgenerate

  assign sync_out = sync_q[SYNC_STAGES-1];

  // Count samples that disagree with the accepted level; a matching sample restarts the count.
  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    if (sync_out == level_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      level_d = sync_out;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
    end
  end

  assign level = level_q;

  // R9: an accepted level is always the synchronized level seen at that edge
  p_filter_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> ($past(sync_out) == level_q));

endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns / 1ps
module i2c_target_fsm
  import i2c_byte_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] cur_value,
  output logic              commit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_pull
);

  localparam logic [BITCNT_W-1:0] RX_FULL = BITCNT_W'(BYTE_W);
  localparam logic [BITCNT_W-1:0] TX_LAST = BITCNT_W'(BYTE_W - 1);

  tgt_state_e            st_q, st_d;
  logic [BITCNT_W-1:0]   cnt_q, cnt_d;
  logic [BYTE_W-1:0]     rx_q, rx_d, tx_q, tx_d;
  logic                  pull_q, pull_d;
  logic                  rw_q, rw_d;
  logic                  mack_q, mack_d;
  logic                  scl_q, sda_q;
  logic                  commit_c;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    pull_d   = pull_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    commit_c = 1'b0;
    if (stop_ev) begin
      st_d   = TS_IDLE;
      pull_d = 1'b0;
    end else if (start_ev) begin
      st_d   = TS_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
    end else begin
      unique case (st_q)
        TS_ADDR: begin
          if (scl_rise && cnt_q < RX_FULL) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + BITCNT_W'(1);
          end else if (scl_fall && cnt_q == RX_FULL) begin
            if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
              pull_d = 1'b1;
              rw_d   = rx_q[0];
              st_d   = TS_ADDR_ACK;
            end else begin
              st_d = TS_WAIT;
            end
          end
        end
        TS_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              tx_d   = cur_value;
              pull_d = ~cur_value[BYTE_W-1];
              st_d   = TS_RD;
            end else begin
              pull_d = 1'b0;
              st_d   = TS_WR;
            end
          end
        end
        TS_WR: begin
          if (scl_rise && cnt_q < RX_FULL) begin
            rx_d  = {rx_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + BITCNT_W'(1);
          end else if (scl_fall && cnt_q == RX_FULL) begin
            commit_c = 1'b1;
            pull_d   = 1'b1;
            st_d     = TS_WR_ACK;
          end
        end
        TS_WR_ACK: begin
          if (scl_fall) begin
            pull_d = 1'b0;
            cnt_d  = '0;
            st_d   = TS_WR;
          end
        end
        TS_RD: begin
          if (scl_fall) begin
            if (cnt_q == TX_LAST) begin
              pull_d = 1'b0;
              st_d   = TS_RD_ACK;
            end else begin
              tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
              pull_d = ~tx_q[BYTE_W-2];
              cnt_d  = cnt_q + BITCNT_W'(1);
            end
          end
        end
        TS_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d   = cur_value;
              pull_d = ~cur_value[BYTE_W-1];
              cnt_d  = '0;
              st_d   = TS_RD;
            end else begin
              st_d = TS_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      pull_q <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      pull_q <= pull_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  assign commit   = commit_c;
  assign rx_byte  = rx_q;
  assign sda_pull = pull_q;

  // R2: the address acknowledge is only ever given for the configured address
  p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_ADDR_ACK) |-> (rx_q[BYTE_W-1:1] == DEV_ADDR));

  // R5: SDA drive changes away from start/stop only when SCL was low
  p_sda_on_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_q != $past(pull_q)) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_f));

  // R7, R8: while waiting for the bus to end, SDA is released
  p_quiet_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_WAIT) |-> !pull_q);

endmodule

// File: rtl/i2c_byte_target.sv
`timescale 1ns / 1ps
module i2c_byte_target
  import i2c_byte_target_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h70,
  parameter int         FILTER_LEN  = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  output logic              scl_o,
  input  logic              sda_i,
  output logic              sda_o,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              load_strobe,
  output logic [BYTE_W-1:0] reg_value
);

  localparam int N_LINES = 2;

  logic [1:0]         rst_pipe;
  logic               rst_sync_n;
  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic               commit, sda_pull;
  logic [BYTE_W-1:0]  rx_byte;
  logic [BYTE_W-1:0]  reg_q, reg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign raw_lines = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      i2c_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILTER_LEN (FILTER_LEN)
      ) i_filter (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .line_in(raw_lines[g]),
        .level  (filt_lines[g])
      );
    end
  endgenerate

  i2c_target_fsm #(
    .DEV_ADDR(DEV_ADDR)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .scl_f    (filt_lines[0]),
    .sda_f    (filt_lines[1]),
    .cur_value(reg_q),
    .commit   (commit),
    .rx_byte  (rx_byte),
    .sda_pull (sda_pull)
  );

  // Bus byte takes priority over a local load in the same clock.
  always_comb begin
    reg_d = reg_q;
    if (commit)           reg_d = rx_byte;
    else if (load_strobe) reg_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) reg_q <= '0;
    else             reg_q <= reg_d;
  end

  assign reg_value = reg_q;
  assign sda_o     = ~sda_pull;
  assign scl_o     = 1'b1;

  // R6: a lone local strobe loads its data on the next clock
  p_latch_load_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_strobe && !commit) |=> (reg_value == $past(load_data)));

  // R10: a committed bus byte is what the register holds next
  p_bus_wins_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    commit |=> (reg_value == $past(rx_byte)));

  // R4, R7, R11: without a commit or a strobe the register holds
  p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load_strobe && !commit) |=> (reg_value == $past(reg_value)));

endmodule

// File: tb/test_i2c_byte_target.sv
`timescale 1ns / 1ps
module test_i2c_byte_target;

  localparam int Q     = 8;
  localparam int FLT   = 4;
  localparam int SYNC  = 2;
  localparam int LAT   = SYNC + FLT;
  localparam logic [6:0] ME = 7'h70;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m, sda_m;
  logic       scl_o, sda_o;
  logic       scl_line, sda_line;
  logic [7:0] load_data;
  logic       load_strobe;
  logic [7:0] reg_value;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  mon_on = 0;
  bit  mon_low = 0;
  logic [7:0] exp_reg;

  always #2.5 clk = ~clk;

  assign scl_line = scl_m & scl_o;
  assign sda_line = sda_m & sda_o;

  i2c_byte_target #(.DEV_ADDR(ME), .FILTER_LEN(FLT), .SYNC_STAGES(SYNC)) i_i2c_byte_target (
    .clk(clk), .rst_n(rst_n),
    .scl_i(scl_line), .scl_o(scl_o),
    .sda_i(sda_line), .sda_o(sda_o),
    .load_data(load_data), .load_strobe(load_strobe),
    .reg_value(reg_value)
  );

  always @(negedge clk) if (mon_on && !sda_o) mon_low = 1;

  function automatic logic [7:0] after_write(logic [7:0] cur, int n, logic [7:0] last);
    return (n == 0) ? cur : last;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(2*Q);
  endtask

  task automatic bit_out(logic b, bit g, int off, logic [7:0] d);
    sda_m = b; wt(Q);
    if (g) begin scl_m = 1; wt(FLT-1); scl_m = 0; wt(Q); end
    scl_m = 1; wt(Q);
    if (g) begin sda_m = ~b; wt(FLT-1); sda_m = b; end
    wt(Q);
    scl_m = 0;
    if (off >= 0) begin
      wt(off); load_data = d; load_strobe = 1; wt(1); load_strobe = 0; wt(Q-off-1);
    end else wt(Q);
  endtask

  task automatic bit_in(output logic v);
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); v = sda_line; wt(Q); scl_m = 0; wt(Q);
  endtask

  task automatic send_byte(logic [7:0] b, bit g, int off, logic [7:0] d, output bit ack);
    logic v;
    for (int i = 7; i >= 0; i--) bit_out(b[i], g, (i == 0) ? off : -1, d);
    bit_in(v);
    ack = !v;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(!give_ack, 0, -1, 8'h00);
  endtask

  task automatic do_latch(logic [7:0] d);
    load_data = d; load_strobe = 1; wt(1); load_strobe = 0;
    exp_reg = d;
    chk("R6 latch", reg_value, exp_reg);
  endtask

  task automatic do_read(int n);
    bit ack; logic [7:0] b;
    i2c_start();
    send_byte({ME, 1'b1}, 0, -1, 0, ack);
    chk("R2 read address ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n-1, b);
      chk("R5 read byte", b, exp_reg);
    end
    i2c_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit ack;
    logic v;
    logic [7:0] b, last;
    void'($urandom(32'h5eed1234));
    rst_n = 0; scl_m = 1; sda_m = 1; load_data = 0; load_strobe = 0;
    wt(5); rst_n = 1; wt(10);

    // R1 reset state
    chk("R1 reset reg", reg_value, 8'h00);
    chk("R1 sda released", {7'd0, sda_o}, 8'd1);
    chk("R1 scl released", {7'd0, scl_o}, 8'd1);
    exp_reg = 8'h00;

    // R6 local load
    do_latch(8'h5A);

    // R2, R3 multi-byte write
    i2c_start();
    send_byte({ME, 1'b0}, 0, -1, 0, ack);
    chk("R2 write address ack", {7'd0, ack}, 8'd1);
    send_byte(8'h11, 0, -1, 0, ack);
    chk("R3 first byte ack", {7'd0, ack}, 8'd1);
    send_byte(8'hAA, 0, -1, 0, ack);
    chk("R3 second byte ack", {7'd0, ack}, 8'd1);
    i2c_stop();
    exp_reg = after_write(exp_reg, 2, 8'hAA);
    chk("R3 last byte kept", reg_value, exp_reg);

    // R4 address-only write
    do_latch(8'h3C);
    i2c_start();
    send_byte({ME, 1'b0}, 0, -1, 0, ack);
    i2c_stop();
    exp_reg = after_write(exp_reg, 0, 8'h00);
    chk("R4 address-only write", reg_value, exp_reg);

    // R5 read several bytes
    do_read(4);

    // R7 foreign addresses
    mon_low = 0; mon_on = 1;
    i2c_start();
    send_byte({7'h55, 1'b0}, 0, -1, 0, ack);
    chk("R7 foreign write not acked", {7'd0, ack}, 8'd0);
    send_byte(8'hDE, 0, -1, 0, ack);
    send_byte(8'hAD, 0, -1, 0, ack);
    i2c_stop();
    i2c_start();
    send_byte({7'h71, 1'b1}, 0, -1, 0, ack);
    chk("R7 near address read not acked", {7'd0, ack}, 8'd0);
    i2c_stop();
    mon_on = 0;
    chk("R7 sda never pulled", {7'd0, mon_low}, 8'd0);
    chk("R7 register unchanged", reg_value, exp_reg);

    // R8 NACK then ignored clocks then repeated start
    i2c_start();
    send_byte({ME, 1'b1}, 0, -1, 0, ack);
    recv_byte(0, b);
    chk("R8 nacked byte value", b, exp_reg);
    for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
    bit_out(1, 0, -1, 0);
    chk("R8 released after nack", b, 8'hFF);
    i2c_start();
    send_byte({ME, 1'b0}, 0, -1, 0, ack);
    chk("R8 repeated start acked", {7'd0, ack}, 8'd1);
    send_byte(8'h96, 0, -1, 0, ack);
    i2c_stop();
    exp_reg = 8'h96;
    chk("R8 write after repeated start", reg_value, exp_reg);

    // R11 stop in the middle of a byte
    i2c_start();
    send_byte({ME, 1'b0}, 0, -1, 0, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b0, 0, -1, 0);
    i2c_stop();
    chk("R11 abandoned byte", reg_value, exp_reg);

    // R9 glitches on both pins
    i2c_start();
    send_byte({ME, 1'b0}, 1, -1, 0, ack);
    chk("R9 glitched address ack", {7'd0, ack}, 8'd1);
    send_byte(8'hC3, 1, -1, 0, ack);
    i2c_stop();
    exp_reg = 8'hC3;
    chk("R9 glitched byte", reg_value, exp_reg);

    // R10 strobe on the commit clock, then one clock later
    i2c_start();
    send_byte({ME, 1'b0}, 0, -1, 0, ack);
    send_byte(8'h12, 0, LAT, 8'hE7, ack);
    i2c_stop();
    exp_reg = 8'h12;
    chk("R10 same clock bus wins", reg_value, exp_reg);
    i2c_start();
    send_byte({ME, 1'b0}, 0, -1, 0, ack);
    send_byte(8'h34, 0, LAT + 1, 8'hE7, ack);
    i2c_stop();
    exp_reg = 8'hE7;
    chk("R10 later strobe wins", reg_value, exp_reg);

    // random mix of R3, R5, R6
    for (int it = 0; it < 8; it++) begin
      int op, n;
      op = $urandom % 3;
      n  = 1 + ($urandom % 3);
      if (op == 0) begin
        do_latch(8'($urandom));
      end else if (op == 1) begin
        last = exp_reg;
        i2c_start();
        send_byte({ME, 1'b0}, 0, -1, 0, ack);
        for (int k = 0; k < n; k++) begin
          last = 8'($urandom);
          send_byte(last, 0, -1, 0, ack);
          chk("R3 random byte ack", {7'd0, ack}, 8'd1);
        end
        i2c_stop();
        exp_reg = after_write(exp_reg, n, last);
        chk("R3 random write", reg_value, exp_reg);
      end else begin
        do_read(n);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule